// File: doc/BRIEF.md
# Banked Scratchpad Memory with In-Memory Atomics

This block is the software-managed working memory that the threads of one compute unit share. It holds 64 KB as 32 independent banks of 512 rows, each row one 32-bit word. A request carries up to 32 lanes, and every lane has its own word address and data word. An enable mask says which lanes take part, and one opcode applies to all of them: read, write, or one of seven integer read-modify-write atomics. The atomics run next to each bank, so a lane gets back the word as it stood before its operation.

Each lane is steered to the bank named by the low five bits of its word address. When active lanes land in different banks, or all read one word, the request takes a single service cycle. When several lanes need different words of one bank, or several lanes write or modify the same bank, the block spends extra service cycles on that bank. While it does so it keeps its request-ready output low. A response-valid pulse marks the completed request, two cycles after the final service cycle. All per-lane results appear together with that pulse.

Top module: `bank_scratchpad`

## Requirements
- R1: A lane's 14-bit word address selects bank = address[4:0] and row = address[13:5]. Two addresses in the same bank but in different rows hold independent words.
- R2: Every active lane returns the word held at its address before the request touched it. A write (opcode 1) stores the lane's data. A later read (opcode 0) returns it.
- R3: After reset, reqReady is 1, rspValid is 0 and every rspData lane is 0.
- R4: Let k be the number of service cycles, with k >= 1. Counting the clock edge that accepts the request as edge 1, rspValid is first seen high after edge k+2. A request with no bank conflict has k = 1.
- R5: Read lanes that share one word address are served together in one service cycle, and all of them receive the same word.
- R6: Within a bank, a read request needs one service cycle per distinct word address, and a write or atomic request needs one service cycle per active lane. k is the maximum over all banks. reqReady stays 0 from acceptance until rspValid has been high, and a request presented meanwhile has no effect.
- R7: The atomic opcodes are 2 add, 3 signed minimum, 4 signed maximum, 5 and, 6 or, 7 xor and 8 swap. Each stores op(old, lane data) and returns old.
- R8: Lanes that write or modify the same word are applied in ascending lane number. Each lane observes the value left by the lower lanes, so for plain writes the highest lane's data remains.
- R9: A lane whose mask bit is 0 returns 0 and changes no memory word, whatever its address, data or opcode.
- R10: rspValid is high for exactly one cycle. rspData holds its value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is presented |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqOp | input | 4 | Opcode for all lanes (0 read, 1 write, 2..8 atomics) |
| reqMask | input | 32 | Per-lane enable |
| reqAddr | input | 448 | Per-lane 14-bit word address, lane n at bits [14n+13:14n] |
| reqData | input | 1024 | Per-lane 32-bit data, lane n at bits [32n+31:32n] |
| rspValid | output | 1 | One-cycle pulse marking a completed request |
| rspData | output | 1024 | Per-lane 32-bit result, same lane packing as reqData |

## Verification
The embedded properties watch four things on every cycle:
- Each busy cycle retires at least one pending lane.
- For writes and atomics, each bank retires exactly one lane per cycle.
- The final service cycle is followed two cycles later by a single-cycle response pulse.
- Results stay frozen while the block is neither accepting nor serving.

Only the directed scenarios can show the rest:
- The actual data values, including the bank and row mapping.
- Read broadcast and the exact cycle counts for given conflict patterns.
- The ascending-lane ordering of same-word atomics.
- The correct arithmetic of each atomic.
- That masked lanes and requests offered while busy leave memory untouched.

// File: rtl/spad_pkg.sv
package spad_pkg;

  typedef enum logic [3:0] {
    OP_READ  = 4'd0,
    OP_WRITE = 4'd1,
    OP_ADD   = 4'd2,
    OP_MIN   = 4'd3,
    OP_MAX   = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_XOR   = 4'd7,
    OP_SWAP  = 4'd8
  } spad_op_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic accept;  // latch a new request
    logic serve;   // one service cycle on the latched request
  } spad_strb_t;

endpackage

// File: rtl/spad_bank.sv
module spad_bank
  import spad_pkg::*;
#(
  parameter  int DW    = 32,
  parameter  int ROWS  = 512,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             en,
  input  spad_op_e         op,
  input  logic [ROW_W-1:0] row,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    oldData
);

  logic [DW-1:0] mem [ROWS];
  logic [DW-1:0] newData;

  assign oldData = mem[row];

  // read-modify-write unit beside the array
  always_comb begin
    case (op)
      OP_WRITE, OP_SWAP: newData = wdata;
      OP_ADD:            newData = oldData + wdata;
      OP_MIN:            newData = ($signed(wdata) < $signed(oldData)) ? wdata : oldData;
      OP_MAX:            newData = ($signed(wdata) > $signed(oldData)) ? wdata : oldData;
      OP_AND:            newData = oldData & wdata;
      OP_OR:             newData = oldData | wdata;
      OP_XOR:            newData = oldData ^ wdata;
      default:           newData = oldData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (en && op != OP_READ) mem[row] <= newData;
  end

endmodule

// File: rtl/spad_datapath.sv
module spad_datapath
  import spad_pkg::*;
#(
  parameter  int LANES  = 32,
  parameter  int BANKS  = 32,
  parameter  int ROWS   = 512,
  parameter  int DW     = 32,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = BANK_W + ROW_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  spad_strb_t              strb,
  input  logic [3:0]              reqOp,
  input  logic [LANES-1:0]        reqMask,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  input  logic [LANES*DW-1:0]     reqData,
  output logic                    lastSvc,
  output logic [LANES*DW-1:0]     rspData
);

  spad_op_e          opR;
  logic [ADDR_W-1:0] addrR    [LANES];
  logic [DW-1:0]     dataR    [LANES];
  logic [DW-1:0]     resR     [LANES];
  logic [BANK_W-1:0] laneBank [LANES];
  logic [LANES-1:0]  pendR, srv, pendNext;

  logic [LANE_W-1:0] selLane [BANKS];
  logic [BANKS-1:0]  anyHit;
  logic              bankEn  [BANKS];
  logic [ROW_W-1:0]  bankRow [BANKS];
  logic [DW-1:0]     bankWd  [BANKS];
  logic [DW-1:0]     bankOld [BANKS];

  always_comb begin
    for (int l = 0; l < LANES; l++) laneBank[l] = addrR[l][BANK_W-1:0];
  end

  // per bank: lowest pending lane wins this cycle
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      selLane[b] = '0;
      anyHit[b]  = 1'b0;
      for (int l = LANES-1; l >= 0; l--) begin
        if (pendR[l] && laneBank[l] == BANK_W'(b)) begin
          selLane[b] = LANE_W'(l);
          anyHit[b]  = 1'b1;
        end
      end
    end
  end

  // reads broadcast to every lane on the chosen word; others retire singly
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      if (opR == OP_READ)
        srv[l] = pendR[l] && (addrR[l] == addrR[selLane[laneBank[l]]]);
      else
        srv[l] = pendR[l] && (selLane[laneBank[l]] == LANE_W'(l));
    end
  end

  assign pendNext = pendR & ~srv;
  assign lastSvc  = strb.serve && (pendNext == '0);

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bankEn[b]  = strb.serve && anyHit[b];
      bankRow[b] = addrR[selLane[b]][ADDR_W-1:BANK_W];
      bankWd[b]  = dataR[selLane[b]];
    end
  end

  for (genvar gb = 0; gb < BANKS; gb++) begin : g_bank
    spad_bank #(.DW(DW), .ROWS(ROWS)) u_bank (
      .clk    (clk),
      .en     (bankEn[gb]),
      .op     (opR),
      .row    (bankRow[gb]),
      .wdata  (bankWd[gb]),
      .oldData(bankOld[gb])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opR   <= OP_READ;
      pendR <= '0;
      for (int l = 0; l < LANES; l++) begin
        addrR[l] <= '0;
        dataR[l] <= '0;
        resR[l]  <= '0;
      end
    end else if (strb.accept) begin
      opR   <= spad_op_e'(reqOp);
      pendR <= reqMask;
      for (int l = 0; l < LANES; l++) begin
        addrR[l] <= reqAddr[l*ADDR_W +: ADDR_W];
        dataR[l] <= reqData[l*DW +: DW];
        resR[l]  <= '0;
      end
    end else if (strb.serve) begin
      pendR <= pendNext;
      for (int l = 0; l < LANES; l++) begin
        if (srv[l]) resR[l] <= bankOld[laneBank[l]];
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) rspData[l*DW +: DW] = resR[l];
  end

  AST_SERVE_PROGRESS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.serve && pendR != '0) |-> (srv != '0))
    else $error("busy cycle retired no lane"); // R6

  AST_ONE_PER_BANK: assert property (@(posedge clk) disable iff (!rstN)
    (strb.serve && opR != OP_READ) |-> ($countones(srv) == $countones(anyHit)))
    else $error("modify cycle retired other than one lane per bank"); // R8

  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.accept && !strb.serve) |=> $stable(rspData))
    else $error("results moved while idle"); // R10

endmodule

// File: rtl/spad_ctrl.sv
module spad_ctrl
  import spad_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       lastSvc,
  output spad_strb_t strb,
  output logic       reqReady,
  output logic       rspValid
);

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DRAIN, ST_RESP} st_e;
  st_e stR, stNext;

  always_comb begin
    strb.accept = (stR == ST_IDLE) && reqValid;
    strb.serve  = (stR == ST_BUSY);
  end

  always_comb begin
    stNext = stR;
    case (stR)
      ST_IDLE:  if (reqValid) stNext = ST_BUSY;
      ST_BUSY:  if (lastSvc)  stNext = ST_DRAIN;
      ST_DRAIN: stNext = ST_RESP;
      default:  stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stR <= ST_IDLE;
    else       stR <= stNext;
  end

  assign reqReady = (stR == ST_IDLE);
  assign rspValid = (stR == ST_RESP);

  AST_LAST_TO_RSP: assert property (@(posedge clk) disable iff (!rstN)
    lastSvc |=> ##1 rspValid)
    else $error("response not two cycles after final service"); // R4

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid)
    else $error("response longer than one cycle"); // R10

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady)
    else $error("ready stayed high after acceptance"); // R6

endmodule

// File: rtl/bank_scratchpad.sv
module bank_scratchpad
  import spad_pkg::*;
#(
  parameter  int LANES  = 32,
  parameter  int BANKS  = 32,
  parameter  int ROWS   = 512,
  parameter  int DW     = 32,
  localparam int ADDR_W = $clog2(BANKS) + $clog2(ROWS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [3:0]              reqOp,
  input  logic [LANES-1:0]        reqMask,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  input  logic [LANES*DW-1:0]     reqData,
  output logic                    rspValid,
  output logic [LANES*DW-1:0]     rspData
);

  spad_strb_t strb;
  logic       lastSvc;

  spad_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .lastSvc (lastSvc),
    .strb    (strb),
    .reqReady(reqReady),
    .rspValid(rspValid)
  );

  spad_datapath #(.LANES(LANES), .BANKS(BANKS), .ROWS(ROWS), .DW(DW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .reqOp  (reqOp),
    .reqMask(reqMask),
    .reqAddr(reqAddr),
    .reqData(reqData),
    .lastSvc(lastSvc),
    .rspData(rspData)
  );

endmodule

// File: tb/bank_scratchpad_bench.sv
`timescale 1ns/1ps
module bank_scratchpad_bench;
  localparam int L  = 32;
  localparam int AW = 14;
  localparam int DW = 32;
  localparam int NB = 32;
  localparam logic [3:0] C_RD = 4'd0, C_WR = 4'd1, C_ADD = 4'd2, C_MIN = 4'd3,
                         C_MAX = 4'd4, C_AND = 4'd5, C_OR = 4'd6, C_XOR = 4'd7,
                         C_SWP = 4'd8;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqReady, rspValid;
  logic [3:0] reqOp = '0;
  logic [L-1:0] reqMask = '0;
  logic [L*AW-1:0] reqAddr = '0;
  logic [L*DW-1:0] reqData = '0, rspData;

  bank_scratchpad u_bank_scratchpad (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqMask(reqMask), .reqAddr(reqAddr), .reqData(reqData),
    .rspValid(rspValid), .rspData(rspData)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] refMem [int];
  logic [AW-1:0] a [L];
  logic [DW-1:0] d [L];
  logic [L-1:0]  m;
  logic [3:0]    op;
  logic [DW-1:0] expRes [L];
  bit            expKnown [L];
  int            expK;
  bit            pokeBusy = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refOp(logic [3:0] o, logic [31:0] old, logic [31:0] arg);
    case (o)
      C_WR, C_SWP: return arg;
      C_ADD: return old + arg;
      C_MIN: return ($signed(arg) < $signed(old)) ? arg : old;
      C_MAX: return ($signed(arg) > $signed(old)) ? arg : old;
      C_AND: return old & arg;
      C_OR:  return old | arg;
      C_XOR: return old ^ arg;
      default: return old;
    endcase
  endfunction

  // sequential ascending-lane model plus service-cycle count per bank
  task automatic model();
    int cnt [NB];
    for (int b = 0; b < NB; b++) cnt[b] = 0;
    for (int l = 0; l < L; l++) begin
      if (m[l]) begin
        bit dup = 0;
        if (op == C_RD)
          for (int j = 0; j < l; j++) if (m[j] && a[j] == a[l]) dup = 1;
        if (!dup) cnt[a[l] % NB]++;
      end
    end
    expK = 1;
    for (int b = 0; b < NB; b++) if (cnt[b] > expK) expK = cnt[b];
    for (int l = 0; l < L; l++) begin
      if (!m[l]) begin
        expRes[l] = '0; expKnown[l] = 1;
      end else begin
        logic [31:0] old;
        int k = int'(a[l]);
        expKnown[l] = refMem.exists(k);
        old = expKnown[l] ? refMem[k] : 32'h0;
        expRes[l] = old;
        if (op != C_RD) refMem[k] = refOp(op, old, d[l]);
      end
    end
  endtask

  task automatic run(string req);
    int n;
    logic [L*DW-1:0] snap;
    model();
    @(negedge clk);
    check(reqReady === 1'b1, req, "ready before request", {31'd0, reqReady}, 32'd1);
    reqValid = 1'b1; reqOp = op; reqMask = m;
    for (int l = 0; l < L; l++) begin
      reqAddr[l*AW +: AW] = a[l];
      reqData[l*DW +: DW] = d[l];
    end
    @(posedge clk);
    @(negedge clk);
    n = 1;
    if (pokeBusy) begin
      reqOp = C_WR; reqMask = 32'h1;
      reqAddr[0 +: AW] = 14'd99; reqData[0 +: DW] = 32'hDEAD_BEEF;
    end else reqValid = 1'b0;
    check(reqReady === 1'b0, "R6", {req, " ready low while busy"}, {31'd0, reqReady}, 32'd0);
    while (rspValid !== 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
    reqValid = 1'b0;
    check(n == expK + 2, "R4", {req, " latency edges"}, n, expK + 2);
    for (int l = 0; l < L; l++) begin
      if (expKnown[l])
        check(rspData[l*DW +: DW] === expRes[l], req, $sformatf("lane %0d data", l),
              rspData[l*DW +: DW], expRes[l]);
    end
    snap = rspData;
    @(negedge clk);
    check(rspValid === 1'b0, "R10", {req, " response pulse width"}, {31'd0, rspValid}, 32'd0);
    check(rspData === snap, "R10", {req, " data held"}, rspData[31:0], snap[31:0]);
  endtask

  task automatic clear();
    m = '0; op = C_RD;
    for (int l = 0; l < L; l++) begin a[l] = '0; d[l] = '0; end
  endtask

  task automatic tReset();
    check(reqReady === 1'b1, "R3", "ready after reset", {31'd0, reqReady}, 32'd1);
    check(rspValid === 1'b0, "R3", "valid after reset", {31'd0, rspValid}, 32'd0);
    check(rspData === '0, "R3", "data after reset", rspData[31:0], 32'd0);
  endtask

  task automatic tFill();
    clear(); op = C_WR; m = '1;
    for (int l = 0; l < L; l++) begin a[l] = AW'(l * 33); d[l] = 32'hA000_0000 + l * 17; end
    run("R2 write spread");
    op = C_RD; run("R2 read spread");
  endtask

  task automatic tMapping();
    clear(); op = C_WR; m = 32'h3;
    a[0] = 14'd5; d[0] = 32'h1111_0005;
    a[1] = 14'd37; d[1] = 32'h2222_0025;
    run("R1 write same bank two rows");
    op = C_RD; m = 32'h7; a[2] = 14'd5;
    run("R1 read rows back");
  endtask

  task automatic tBroadcast();
    clear(); op = C_RD; m = '1;
    for (int l = 0; l < L; l++) a[l] = 14'd33;
    run("R5 broadcast read");
  endtask

  task automatic tConflict();
    clear(); op = C_WR; m = 32'hF;
    for (int r = 0; r < 4; r++) begin a[r] = AW'(3 + 32 * r); d[r] = 32'hC0DE_0000 + r; end
    run("R6 write four rows one bank");
    op = C_RD; m = '1;
    for (int l = 4; l < L; l++) a[l] = AW'(l * 33);
    pokeBusy = 1;
    run("R6 read four rows one bank");
    pokeBusy = 0;
    clear(); op = C_RD; m = 32'h1; a[0] = 14'd99;
    run("R6 request during busy ignored");
  endtask

  task automatic tAtomics();
    logic [3:0] ops [7];
    ops = '{C_ADD, C_MIN, C_MAX, C_AND, C_OR, C_XOR, C_SWP};
    clear(); op = C_WR; m = 32'hF;
    for (int l = 0; l < 4; l++) begin a[l] = AW'(200 + l); d[l] = 32'hFFFF_FFF0 + l; end
    run("R7 atomic setup");
    for (int i = 0; i < 7; i++) begin
      op = ops[i];
      for (int l = 0; l < 4; l++) d[l] = (i[0] ? 32'hFFFF_FFF5 : 32'h0000_00F3) + 32'(l * 9 + i);
      run($sformatf("R7 atomic op %0d", ops[i]));
    end
    op = C_RD; run("R7 atomic result readback");
  endtask

  task automatic tOrdering();
    clear(); op = C_WR; m = 32'h1; a[0] = 14'd300; d[0] = 32'd100;
    run("R8 base write");
    op = C_ADD; m = 32'hFF;
    for (int l = 0; l < 8; l++) begin a[l] = 14'd300; d[l] = 32'(l + 1); end
    run("R8 same word adds");
    op = C_WR; m = 32'hF;
    for (int l = 0; l < 4; l++) d[l] = 32'h5A00_0000 + l;
    run("R8 same word writes");
    op = C_RD; m = 32'h1;
    run("R8 last lane wins");
    check(refMem[300] == 32'h5A00_0003, "R8", "model final", refMem[300], 32'h5A00_0003);
  endtask

  task automatic tMask();
    clear(); op = C_WR; m = 32'h5555_5555;
    for (int l = 0; l < L; l++) begin
      a[l] = l[0] ? 14'd33 : AW'(400 + l);
      d[l] = 32'hBAD0_0000 + l;
    end
    run("R9 masked write");
    clear(); op = C_RD; m = 32'h1; a[0] = 14'd33;
    run("R9 masked lanes untouched");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFill();
    tMapping();
    tBroadcast();
    tConflict();
    tAtomics();
    tOrdering();
    tMask();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5 * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule